// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block runs an 8-bit successive-approximation conversion. An external DAC and an analog comparator are attached to it. The block drives a trial code to the DAC and reads back one comparator bit, which reports whether the analog input lies above that trial level. It settles one result bit per step, working from the most significant bit down. The first trial is one code below mid-scale. Every later trial keeps the bits already settled, puts a 0 in the position now under test and sets every position below it to 1.

Software reaches the block through a small register port with 8-bit data and one address bit. A control write does three things: it picks one of four reference levels, asserts the hold line for the sample/hold and starts a conversion. The status register reports completion and activity. The data register returns the last result. The comparator bit passes through a two-stage synchronizer, and each step is long enough to absorb that latency.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, `dac_code_o` is 0, `hold_o` is 0, `ref_sel_o` is 0, and reads of both offsets return 0.
- R2: `ack_o` is high in every cycle where `cyc_i` and `stb_i` are both high, so every access takes zero wait states. Read data appears in the same cycle. Offset 0 (`adr_i`=0) returns the result. Offset 1 returns status, with done in bit 0, busy in bit 1, the reference select in bits 3:2 and 0 in the upper bits.
- R3: When the block is idle, a write to offset 1 loads `ref_sel_o` from `dat_i[1:0]`. If `dat_i[2]` is 1, the same write starts a conversion. `hold_o` stays high for the whole conversion.
- R4: On the clock edge that accepts a start, `dac_code_o` becomes 0x7F.
- R5: Each bit step lasts exactly 3 clock cycles. The comparator bit is taken from the output of a two-flop synchronizer at the end of the step.
- R6: At the end of each step, the bit under test takes the synchronized comparator value. The next lower bit becomes 0 and all bits below it become 1. The bits above the bit under test do not change.
- R7: With an ideal comparator (`cmp_i` = input > `dac_code_o`), the result equals the input value for every input from 0 to 255. The result is held on `dac_code_o` and can be read at offset 0.
- R8: Done rises, and `hold_o` falls, exactly 24 cycles after the start edge, which is the cycle after the LSB is settled. Until that point, done stays 0.
- R9: While a conversion is running, a write to offset 1 changes nothing: it neither restarts the conversion nor changes the reference select. Done clears on the edge that starts a new conversion.
- R10: A write to offset 0 has no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | 1 | Register select: 0 data, 1 control/status |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data |
| ack_o | output | 1 | Access acknowledge |
| dac_code_o | output | 8 | Trial code to the external DAC |
| ref_sel_o | output | 2 | Reference level select |
| hold_o | output | 1 | Sample/hold hold command, high while converting |
| cmp_i | input | 1 | Asynchronous comparator output |

## Verification
A wrong trial code or a wrongly settled bit appears on `dac_code_o` within one 3-cycle step. From that point it spreads into every later trial and into the final result. A sweep of all 256 input values compares every trial code against the one computed from the input, so an error is caught in the step where it first happens. An error in step timing or in the length of the synchronizer moves the done edge away from cycle 24. An error in the busy guard shows up as a changed reference select, or as a result that does not match, after a write made in the middle of a conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  parameter int unsigned SAR_RES_W = 8;
  parameter int unsigned SAR_BUS_W = 8;
  parameter int unsigned SAR_SYNC  = 2;

  typedef logic [SAR_RES_W-1:0] sar_code_t;

  // Mid-scale minus one: every bit set except the MSB.
  function automatic sar_code_t sar_first_trial();
    sar_code_t c;
    c = '1;
    c[SAR_RES_W-1] = 1'b0;
    return c;
  endfunction

  // Settle bit idx to cmp_bit, open the next lower bit with a 0.
  function automatic sar_code_t sar_next_trial(sar_code_t code,
                                               int unsigned idx,
                                               logic cmp_bit);
    sar_code_t c;
    c = code;
    for (int unsigned i = 0; i < SAR_RES_W; i++) begin
      if (i == idx) c[i] = cmp_bit;
      else if (i + 1 == idx) c[i] = 1'b0;
      else if (i + 1 < idx) c[i] = 1'b1;
    end
    return c;
  endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int unsigned STEP_CYC = SAR_SYNC + 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      cmp_sync,
  output logic      busy,
  output logic      done,
  output sar_code_t code,
  output sar_code_t result,
  output logic      step_evt
);
  localparam int unsigned IDX_W  = $clog2(SAR_RES_W);
  localparam int unsigned WAIT_W = $clog2(STEP_CYC + 1);

  logic [IDX_W-1:0]  bit_idx;
  logic [WAIT_W-1:0] wait_cnt;
  logic              last_bit;
  sar_code_t         next_code;

  assign step_evt  = busy && (wait_cnt == WAIT_W'(STEP_CYC - 1));
  assign last_bit  = (bit_idx == '0);
  assign next_code = sar_next_trial(code, int'(bit_idx), cmp_sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      code     <= '0;
      result   <= '0;
      bit_idx  <= '0;
      wait_cnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        done     <= 1'b0;
        code     <= sar_first_trial();
        bit_idx  <= IDX_W'(SAR_RES_W - 1);
        wait_cnt <= '0;
      end
    end else if (step_evt) begin
      code     <= next_code;
      wait_cnt <= '0;
      if (last_bit) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= next_code;
      end else begin
        bit_idx <= bit_idx - 1'b1;
      end
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cyc,
  input  logic                 stb,
  input  logic                 we,
  input  logic                 adr,
  input  logic [SAR_BUS_W-1:0] wdata,
  output logic [SAR_BUS_W-1:0] rdata,
  output logic                 ack,
  input  logic                 busy,
  input  logic                 done,
  input  sar_code_t            result,
  output logic [1:0]           ref_sel,
  output logic                 start
);
  localparam int unsigned START_BIT = 2;

  logic access, ctrl_wr;

  assign access  = cyc && stb;
  assign ack     = access;
  assign ctrl_wr = access && we && adr && !busy;
  assign start   = ctrl_wr && wdata[START_BIT];

  always_ff @(posedge clk) begin
    if (rst)          ref_sel <= 2'b00;
    else if (ctrl_wr) ref_sel <= wdata[1:0];
  end

  always_comb begin
    rdata = '0;
    if (adr) begin
      rdata[0]   = done;
      rdata[1]   = busy;
      rdata[3:2] = ref_sel;
    end else begin
      rdata[SAR_RES_W-1:0] = result;
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 cyc_i,
  input  logic                 stb_i,
  input  logic                 we_i,
  input  logic                 adr_i,
  input  logic [SAR_BUS_W-1:0] dat_i,
  output logic [SAR_BUS_W-1:0] dat_o,
  output logic                 ack_o,
  output logic [SAR_RES_W-1:0] dac_code_o,
  output logic [1:0]           ref_sel_o,
  output logic                 hold_o,
  input  logic                 cmp_i
);
  localparam int unsigned STEP_CYC = SAR_SYNC + 1;

  logic      cmp_sync, eng_busy, eng_done, start_req, step_evt;
  sar_code_t eng_code, eng_result;

  sar_sync #(.STAGES(SAR_SYNC)) u_sync (
    .clk(clk_i), .rst(rst_i), .d(cmp_i), .q(cmp_sync)
  );

  sar_engine #(.STEP_CYC(STEP_CYC)) u_engine (
    .clk(clk_i), .rst(rst_i), .start(start_req), .cmp_sync(cmp_sync),
    .busy(eng_busy), .done(eng_done), .code(eng_code),
    .result(eng_result), .step_evt(step_evt)
  );

  sar_regs u_regs (
    .clk(clk_i), .rst(rst_i), .cyc(cyc_i), .stb(stb_i), .we(we_i),
    .adr(adr_i), .wdata(dat_i), .rdata(dat_o), .ack(ack_o),
    .busy(eng_busy), .done(eng_done), .result(eng_result),
    .ref_sel(ref_sel_o), .start(start_req)
  );

  assign dac_code_o = eng_code;
  assign hold_o     = eng_busy;
endmodule

// File: rtl/sar_adc_checker.sv
module sar_adc_checker #(
  parameter int unsigned RES_W    = 8,
  parameter int unsigned STEP_CYC = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             step_evt,
  input logic [RES_W-1:0] code,
  input logic [1:0]       ref_sel
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (code == {1'b0, {(RES_W-1){1'b1}}}));   // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !done);                                 // R9
  AST_REF_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ref_sel));            // R9
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !step_evt) |=> $stable(code));                 // R5
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && busy_cnt == 16'(RES_W * STEP_CYC)));  // R8
endmodule

bind sar_adc_ctrl sar_adc_checker #(.RES_W(sar_pkg::SAR_RES_W),
                                    .STEP_CYC(sar_pkg::SAR_SYNC + 1)) u_chk (
  .clk(clk_i), .rst(rst_i), .busy(eng_busy), .done(eng_done),
  .step_evt(step_evt), .code(dac_code_o), .ref_sel(ref_sel_o)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
  logic       clk_i = 1'b0, rst_i = 1'b1;
  logic       cyc_i = 0, stb_i = 0, we_i = 0, adr_i = 0;
  logic [7:0] dat_i = 0, dat_o, dac_code_o;
  logic       ack_o, hold_o, cmp_i;
  logic [1:0] ref_sel_o;
  int unsigned vin = 0;
  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  assign cmp_i = (vin > int'(dac_code_o));

  sar_adc_ctrl dut (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Combinational read at the current negedge; returns data.
  task automatic rd(input logic a, output logic [7:0] d);
    cyc_i = 1; stb_i = 1; we_i = 0; adr_i = a;
    #1;
    d = dat_o;
    check("R2 ack", int'(ack_o), 1);
    cyc_i = 0; stb_i = 0;
  endtask

  // Write accepted on the next posedge; returns at the following negedge.
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    cyc_i = 1; stb_i = 1; we_i = 1; adr_i = a; dat_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    cyc_i = 0; stb_i = 0; we_i = 0;
  endtask

  function automatic int trial(int v, int k);
    int hi = v & ~((1 << (k + 1)) - 1);
    return hi | ((1 << k) - 1);
  endfunction

  task automatic convert(int v, int rsel, bit inject);
    logic [7:0] d;
    int bad_codes = 0;
    vin = v;
    wr(1'b1, 8'(4 | rsel));
    check("R4 first trial", int'(dac_code_o), 'h7F);
    check("R3 ref/hold", int'({hold_o, ref_sel_o}), 4 | rsel);
    rd(1'b1, d);
    check("R9 done cleared at start", int'(d[1:0]), 2);
    for (int n = 1; n <= 24; n++) begin
      if (inject && n == 10) begin
        cyc_i = 1; stb_i = 1; we_i = 1; adr_i = 1;
        dat_i = 8'(4 | ((rsel + 1) & 3));
      end
      @(negedge clk_i);
      if (inject && n == 10) begin
        cyc_i = 0; stb_i = 0; we_i = 0;
        check("R9 ref frozen", int'(ref_sel_o), rsel);
      end
      if (n < 24 && int'(dac_code_o) != trial(v, 7 - n / 3)) bad_codes++;
      if (n == 23) check("R8 not done early", int'({hold_o, dat_o[0]}), 2);
    end
    check("R5 R6 trial sequence", bad_codes, 0);
    rd(1'b1, d);
    check("R8 done/hold", int'({hold_o, d[1:0]}), 1);
    rd(1'b0, d);
    check("R7 result", int'(d), v);
    check("R7 code holds result", int'(dac_code_o), v);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_i = 0;
    check("R1 code", int'(dac_code_o), 0);
    check("R1 hold/ref", int'({hold_o, ref_sel_o}), 0);
    rd(1'b0, d); check("R1 data", int'(d), 0);
    rd(1'b1, d); check("R1 status", int'(d), 0);
    cyc_i = 1; stb_i = 0; #1;
    check("R2 no ack without strobe", int'(ack_o), 0);
    cyc_i = 0;

    for (int v = 0; v < 256; v++) convert(v, v & 3, 1'b0);

    convert(200, 1, 1'b1);
    convert(37, 2, 1'b1);

    wr(1'b0, 8'h55);
    check("R10 no start", int'(hold_o), 0);
    rd(1'b0, d); check("R10 data kept", int'(d), 37);
    rd(1'b1, d); check("R10 status kept", int'(d), 1 | (2 << 2));

    // ref-only write when idle
    wr(1'b1, 8'h03);
    check("R3 ref-only write", int'({hold_o, ref_sel_o}), 3);
    rd(1'b1, d); check("R3 done kept", int'(d[0]), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule